// File: doc/BRIEF.md
# UART Loopback Diagnostic Controller

This block holds the self-test loopback logic of a 16550-class serial port. When the loopback bit in the modem control register is set, the transmit bit coming from the transmit shifter goes straight back to the receive shifter within the same cycle. The host can then check both data paths without touching the line. In this mode the external serial output rests at mark and the four modem control outputs are driven inactive.

The block also tracks modem status. In normal mode it reads the four external modem inputs through a synchroniser. In loopback it reads the four low modem control bits instead. It records a change flag for each status line. It raises a modem-status interrupt request when a flag is set and the interrupt enable register allows it. The gating works the same way in both modes.

The shifters, baud timing and FIFOs are outside this block and appear only as single-bit serial ports. The register port is a plain single-cycle strobe interface with no back-pressure: a write takes effect at the clock edge, and read data is combinational while the read strobe is high.

Top module: `uart_loopback_ctl`

## Requirements
- R1: After reset, the modem control register and the interrupt enable register read 0, the modem status register (offset 6) reads 0, `modem_irq` is 0, and `ser_out` follows `core_txd`.
- R2: With loopback off, `core_rxd` equals `ser_in`, `ser_out` equals `core_txd`, and `out_dtr`, `out_rts`, `out_out1`, `out_out2` equal modem control bits 0, 1, 2 and 3.
- R3: With loopback on (modem control register at offset 4, bit 4), `core_rxd` equals `core_txd` in the same cycle, `ser_out` is 1, and all four modem outputs are 0.
- R4: Modem control bits 7:5 always read 0 and ignore writes. Interrupt enable register (offset 1) bits 7:4 always read 0.
- R5: In loopback, the status source is taken from the control bits: CTS = bit 1, DSR = bit 0, RI = bit 2, DCD = bit 3. The external modem pins have no effect. Status bits 4, 5, 6, 7 show CTS, DSR, RI, DCD.
- R6: The change flags for CTS (status bit 0), DSR (bit 1) and DCD (bit 3) set on any change of their source.
- R7: The RI flag (status bit 2) sets only when RI goes from 1 to 0.
- R8: Reading the status register clears all four flags at that clock edge. A flag that sets in the same cycle as the read stays set.
- R9: `modem_irq` is 1 exactly when interrupt enable bit 3 is 1 and at least one change flag is set. This holds in both modes.
- R10: With loopback off, a change on an external modem pin sets its flag exactly SYNC_STAGES+1 clock cycles after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; a read at offset 6 clears the change flags |
| reg_rdata | output | 8 | Read data, valid while `reg_rd` is high |
| core_txd | input | 1 | Bit from the transmit shifter |
| core_rxd | output | 1 | Bit to the receive shifter |
| ser_in | input | 1 | External serial input |
| ser_out | output | 1 | External serial output |
| pin_cts | input | 1 | Clear-to-send, active high |
| pin_dsr | input | 1 | Data-set-ready, active high |
| pin_ri | input | 1 | Ring indicator, active high |
| pin_dcd | input | 1 | Carrier detect, active high |
| out_dtr | output | 1 | Data-terminal-ready output |
| out_rts | output | 1 | Request-to-send output |
| out_out1 | output | 1 | User output 1 |
| out_out2 | output | 1 | User output 2 |
| modem_irq | output | 1 | Modem-status interrupt request |

## Verification
The risky overlap is a status-register read that lands in the same cycle as a new status change: the clear and the set both aim at the same flag register. The bench provokes this in loopback by writing a new RTS value and reading the status register in the very next cycle, which is the cycle in which the change flag sets. A second read must still show the CTS change flag. Random mixes of mode switches, pin changes and reads also make clears and sets meet, and every read is compared with a model that accumulates flags per settled transition.

// File: rtl/ulb_pkg.sv
package ulb_pkg;
  localparam int ULB_AW = 3;
  localparam int ULB_DW = 8;

  // register offsets
  localparam logic [ULB_AW-1:0] OFS_IEN   = 3'd1;
  localparam logic [ULB_AW-1:0] OFS_MCTL  = 3'd4;
  localparam logic [ULB_AW-1:0] OFS_MSTAT = 3'd6;

  // field widths
  localparam int IEN_W  = 4;
  localparam int MCTL_W = 5;
  localparam int NSIG   = 4;

  // modem control bits
  localparam int MC_DTR  = 0;
  localparam int MC_RTS  = 1;
  localparam int MC_OUT1 = 2;
  localparam int MC_OUT2 = 3;
  localparam int MC_LOOP = 4;

  // interrupt enable bit for modem status
  localparam int IEN_MSI = 3;

  // status signal order (flag bit i, level bit i+NSIG)
  localparam int ST_CTS = 0;
  localparam int ST_DSR = 1;
  localparam int ST_RI  = 2;
  localparam int ST_DCD = 3;

  // status source taken from control bits during loopback
  function automatic logic [NSIG-1:0] loop_map(input logic [NSIG-1:0] mc);
    logic [NSIG-1:0] s;
    s[ST_CTS] = mc[MC_RTS];
    s[ST_DSR] = mc[MC_DTR];
    s[ST_RI]  = mc[MC_OUT1];
    s[ST_DCD] = mc[MC_OUT2];
    return s;
  endfunction
endpackage

// File: rtl/ulb_sync.sv
module ulb_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign d_out = d_in;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else if (s == 0) stage_q[s] <= d_in;
          else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
      assign d_out = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ulb_regs.sv
module ulb_regs
  import ulb_pkg::*;
#(
  parameter int AW = ULB_AW,
  parameter int DW = ULB_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              reg_rd,
  output logic [DW-1:0]     reg_rdata,
  input  logic [2*NSIG-1:0] stat_val,
  output logic [IEN_W-1:0]  ien_q,
  output logic [MCTL_W-1:0] mctl_q,
  output logic              stat_clr
);
  logic hit_ien, hit_mctl, hit_stat;
  logic [DW-1:0] rd_mux;
  logic unused_wdata;

  assign hit_ien  = (reg_addr == OFS_IEN[AW-1:0]);
  assign hit_mctl = (reg_addr == OFS_MCTL[AW-1:0]);
  assign hit_stat = (reg_addr == OFS_STAT_FIX);

  localparam logic [AW-1:0] OFS_STAT_FIX = OFS_MSTAT[AW-1:0];

  assign unused_wdata = ^reg_wdata[DW-1:MCTL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      mctl_q <= '0;
    end else if (reg_wr) begin
      if (hit_ien)  ien_q  <= reg_wdata[IEN_W-1:0];
      if (hit_mctl) mctl_q <= reg_wdata[MCTL_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ien)       rd_mux[IEN_W-1:0]  = ien_q;
    else if (hit_mctl) rd_mux[MCTL_W-1:0] = mctl_q;
    else if (hit_stat) rd_mux[2*NSIG-1:0] = stat_val;
  end

  assign reg_rdata = reg_rd ? rd_mux : '0;
  assign stat_clr  = reg_rd && hit_stat;

  // R4: upper control bits never read back as one
  p_mctl_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && hit_mctl) |-> (reg_rdata[DW-1:MCTL_W] == '0));

  // R4: upper enable bits never read back as one
  p_ien_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && hit_ien) |-> (reg_rdata[DW-1:IEN_W] == '0));
endmodule

// File: rtl/ulb_route.sv
module ulb_route
  import ulb_pkg::*;
(
  input  logic            loop_en,
  input  logic [NSIG-1:0] mc_lo,
  input  logic            core_txd,
  input  logic            ser_in,
  input  logic [NSIG-1:0] pins_sync,
  output logic            core_rxd,
  output logic            ser_out,
  output logic [NSIG-1:0] mc_out,
  output logic [NSIG-1:0] stat_src
);
  // serial path: transmit feeds receive in loopback, line idles at mark
  assign core_rxd = loop_en ? core_txd : ser_in;
  assign ser_out  = loop_en ? 1'b1 : core_txd;

  // modem outputs forced inactive during loopback
  assign mc_out   = loop_en ? '0 : mc_lo;

  // status source selection
  assign stat_src = loop_en ? loop_map(mc_lo) : pins_sync;
endmodule

// File: rtl/ulb_mstat.sv
module ulb_mstat
  import ulb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] src,
  input  logic            clr,
  input  logic            irq_en,
  output logic [NSIG-1:0] level_q,
  output logic [NSIG-1:0] flag_q,
  output logic            irq
);
  logic [NSIG-1:0] set_v;
  logic [NSIG-1:0] flag_d;

  generate
    for (genvar i = 0; i < NSIG; i++) begin : g_det
      if (i == ST_RI) begin : g_trail
        assign set_v[i] = level_q[i] & ~src[i];
      end else begin : g_any
        assign set_v[i] = level_q[i] ^ src[i];
      end
    end
  endgenerate

  // a set in the read cycle wins over the clear
  assign flag_d = (clr ? '0 : flag_q) | set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      flag_q  <= '0;
    end else begin
      level_q <= src;
      flag_q  <= flag_d;
    end
  end

  assign irq = irq_en & (|flag_q);

  // R7: a freshly set ring flag follows a falling ring level
  p_ri_trail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((!$past(flag_q[ST_RI]) || $past(clr)) && flag_q[ST_RI])
      |-> ($past(level_q[ST_RI]) && !$past(src[ST_RI])));

  // R8: a read with no pending change leaves every flag clear
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) && ($past(src) == $past(level_q))) |-> (flag_q == '0));

  // R6: no change and no read means the flags hold
  p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && ($past(src) == $past(level_q))) |-> $stable(flag_q));
endmodule

// File: rtl/uart_loopback_ctl.sv
module uart_loopback_ctl
  import ulb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ULB_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [ULB_DW-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [ULB_DW-1:0] reg_rdata,
  input  logic              core_txd,
  output logic              core_rxd,
  input  logic              ser_in,
  output logic              ser_out,
  input  logic              pin_cts,
  input  logic              pin_dsr,
  input  logic              pin_ri,
  input  logic              pin_dcd,
  output logic              out_dtr,
  output logic              out_rts,
  output logic              out_out1,
  output logic              out_out2,
  output logic              modem_irq
);
  logic [IEN_W-1:0]  ien_q;
  logic [MCTL_W-1:0] mctl_q;
  logic              stat_clr;
  logic [NSIG-1:0]   pins_raw, pins_sync, stat_src, mc_out;
  logic [NSIG-1:0]   level_q, flag_q;
  logic              loop_en;

  assign pins_raw[ST_CTS] = pin_cts;
  assign pins_raw[ST_DSR] = pin_dsr;
  assign pins_raw[ST_RI]  = pin_ri;
  assign pins_raw[ST_DCD] = pin_dcd;
  assign loop_en          = mctl_q[MC_LOOP];

  ulb_regs #(.AW(ULB_AW), .DW(ULB_DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .stat_val  ({level_q, flag_q}),
    .ien_q     (ien_q),
    .mctl_q    (mctl_q),
    .stat_clr  (stat_clr)
  );

  ulb_sync #(.STAGES(SYNC_STAGES), .WIDTH(NSIG)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pins_raw),
    .d_out (pins_sync)
  );

  ulb_route u_route (
    .loop_en   (loop_en),
    .mc_lo     (mctl_q[NSIG-1:0]),
    .core_txd  (core_txd),
    .ser_in    (ser_in),
    .pins_sync (pins_sync),
    .core_rxd  (core_rxd),
    .ser_out   (ser_out),
    .mc_out    (mc_out),
    .stat_src  (stat_src)
  );

  ulb_mstat u_mstat (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (stat_src),
    .clr     (stat_clr),
    .irq_en  (ien_q[IEN_MSI]),
    .level_q (level_q),
    .flag_q  (flag_q),
    .irq     (modem_irq)
  );

  assign out_dtr  = mc_out[MC_DTR];
  assign out_rts  = mc_out[MC_RTS];
  assign out_out1 = mc_out[MC_OUT1];
  assign out_out2 = mc_out[MC_OUT2];

  // R3: loopback quiets the line and the modem outputs
  p_loop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (ser_out && !out_dtr && !out_rts && !out_out1 && !out_out2));

  // R3: transmit bit reaches the receiver during loopback
  p_loop_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (core_rxd == core_txd));

  // R9: request only with the enable bit set
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    modem_irq |-> ien_q[IEN_MSI]);

  // R5: loopback level of CTS tracks RTS one cycle later
  p_loop_cts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(loop_en) && loop_en) |-> (level_q[ST_CTS] == $past(mctl_q[MC_RTS])));
endmodule

// File: tb/test_uart_loopback_ctl.sv
module test_uart_loopback_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       core_txd = 1'b1;
  logic       core_rxd;
  logic       ser_in = 1'b1;
  logic       ser_out;
  logic [3:0] pv = '0;   // {dcd, ri, dsr, cts}
  logic       out_dtr, out_rts, out_out1, out_out2, modem_irq;

  int checks = 0;
  int errors = 0;
  logic [4:0] m_mctl = '0;
  logic [3:0] m_ien = '0;
  logic [3:0] m_src = '0;
  logic [3:0] m_flag = '0;

  localparam int SYNC = 2;

  always #4 clk = ~clk;

  uart_loopback_ctl #(.SYNC_STAGES(SYNC)) i_uart_loopback_ctl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .core_txd(core_txd), .core_rxd(core_rxd), .ser_in(ser_in), .ser_out(ser_out),
    .pin_cts(pv[0]), .pin_dsr(pv[1]), .pin_ri(pv[2]), .pin_dcd(pv[3]),
    .out_dtr(out_dtr), .out_rts(out_rts), .out_out1(out_out1), .out_out2(out_out2),
    .modem_irq(modem_irq)
  );

  function automatic logic [3:0] src_fn(input logic [4:0] mc, input logic [3:0] p);
    return mc[4] ? {mc[3], mc[2], mc[0], mc[1]} : p;
  endfunction

  function automatic logic [3:0] flag_fn(input logic [3:0] o, input logic [3:0] n);
    logic [3:0] d;
    d = o ^ n;
    d[2] = o[2] & ~n[2];
    return d;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
    if (a == 3'd4) m_mctl = d[4:0];
    if (a == 3'd1) m_ien = d[3:0];
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic settle();
    logic [3:0] ns;
    repeat (4) @(negedge clk);
    ns = src_fn(m_mctl, pv);
    m_flag = m_flag | flag_fn(m_src, ns);
    m_src = ns;
  endtask

  task automatic check_stat(input string req);
    logic [7:0] d;
    rd(3'd6, d);
    check(req, d, {m_src, m_flag});
    m_flag = '0;
  endtask

  task automatic check_path(input string req);
    #1;
    if (m_mctl[4]) begin
      check({req, " R3 rxd"}, core_rxd, core_txd);
      check({req, " R3 pins"}, {ser_out, out_out2, out_out1, out_rts, out_dtr}, 5'b10000);
    end else begin
      check({req, " R2 rxd"}, core_rxd, ser_in);
      check({req, " R2 pins"}, {ser_out, out_out2, out_out1, out_rts, out_dtr},
            {core_txd, m_mctl[3:0]});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd7151));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd4, d); check("R1 mctl", d, 8'h00);
    rd(3'd1, d); check("R1 ien", d, 8'h00);
    rd(3'd6, d); check("R1 mstat", d, 8'h00);
    check("R1 irq", modem_irq, 1'b0);
    core_txd = 1'b0; #1 check("R1 ser_out", ser_out, 1'b0);

    // R4 high bits
    wr(3'd4, 8'hEF); rd(3'd4, d); check("R4 mctl", d, 8'h0F);
    wr(3'd1, 8'hF8); rd(3'd1, d); check("R4 ien", d, 8'h08);
    settle(); check_stat("R6 R2 outputs to status");

    // R10 pin latency, normal mode, ien bit3 set
    wr(3'd4, 8'h00); settle(); check_stat("R6 clear");
    pv[0] = 1'b1;
    repeat (SYNC) @(negedge clk);
    check("R10 not yet", modem_irq, 1'b0);
    @(negedge clk);
    check("R10 flag set", modem_irq, 1'b1);
    settle(); check_stat("R10 status");

    // R7 ring: rising gives no flag, falling does
    pv[2] = 1'b1; settle(); check_stat("R7 rise");
    pv[2] = 1'b0; settle(); check_stat("R7 fall");

    // R5 loopback ignores pins
    wr(3'd4, 8'h10); settle(); check_stat("R5 enter");
    pv = 4'hF; settle(); check_stat("R5 pins ignored");
    check_path("R3 loop");
    core_txd = 1'b1; check_path("R3 loop");

    // R8 read in the cycle the flag sets
    wr(3'd4, 8'h12);
    rd(3'd6, d);
    check("R8 early read", d, {m_src, 4'h0});
    rd(3'd6, d);
    check("R8 set wins", d, 8'h11);
    m_src = src_fn(m_mctl, pv); m_flag = '0;

    // R9 gating
    wr(3'd4, 8'h11); settle();
    wr(3'd1, 8'h00); #1 check("R9 masked", modem_irq, 1'b0);
    wr(3'd1, 8'h08); #1 check("R9 enabled", modem_irq, 1'b1);

    // random mix
    for (int it = 0; it < 300; it++) begin
      case ($urandom % 5)
        0: wr(3'd4, 8'($urandom));
        1: pv = 4'($urandom);
        2: check_stat("R6 R7 R8 random status");
        3: wr(3'd1, 8'($urandom));
        default: begin
          rd(3'd4, d); check("R4 random mctl", d, {3'b000, m_mctl});
          rd(3'd1, d); check("R4 random ien", d, {4'h0, m_ien});
        end
      endcase
      settle();
      check("R9 random irq", modem_irq, m_ien[3] & (|m_flag));
      core_txd = 1'($urandom); ser_in = 1'($urandom);
      check_path("random path");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule